// File: doc/BRIEF.md
# Multi-Source Output Sync Controller

This block decides when the channel dividers of a clock distribution path are held in their preset state, and it releases them together once every cause of that hold is gone. Several causes can request the hold. There is an asynchronous active-low sync pin, and two more active-low pins, chip reset and power-down. Three control bits can be programmed through a simple write port: soft sync, distribution power-down and soft reset. A calibration-busy flag also requests the hold, and so does a fixed hold that the block runs by itself right after its own reset is released.

All of these requests are merged by OR into one sync request. That request is sent to each of the channels as a registered sync-active output. A channel whose ignore bit is set never sees the request.

The programmable bits are double-buffered. A write only changes the staging copy. An update strobe then copies all staging bits to the active copy in a single cycle, so several changes take effect together. The three pins are asynchronous to the divider clock, so each one passes through its own two-flop synchronizer before it joins the merge.

Top module: `sync_merge_ctrl`

## Requirements
- R1: While `rst` is high, every bit of `ch_sync_act` is 0, and both the staging and the active copies of the control bits and the ignore mask are cleared. After reset, no sync remains that was programmed before it.
- R2: After `rst` falls, every channel is asserted for exactly PWRUP_HOLD (default 8) cycles. The first asserted cycle follows the first clock edge at which `rst` is low.
- R3: A low level on `sync_pin_n` asserts every non-ignored channel on the third rising edge after the pin falls: two synchronizer flops, then the output register. The channels stay asserted for as long as the pin is low. They release on the third edge after the pin rises.
- R4: A low level on `chip_rst_n` or on `pwr_dn_n` asserts the non-ignored channels with the same three-edge latency as R3, both when asserting and when releasing.
- R5: A write with `wr_addr` = 0 stages the control bits: bit 0 is soft sync, bit 1 is distribution power-down, bit 2 is soft reset. A write with `wr_addr` = 1 stages the ignore mask, where bit i belongs to channel i. Neither kind of write changes `ch_sync_act` until an update strobe.
- R6: When `update_all` is high at an edge, both staging copies move into the active copies at that edge, and the outputs follow on the next edge. Any active control bit keeps the non-ignored channels asserted until a cleared value is written and committed by another update.
- R7: When `cal_busy` is high, every non-ignored channel is asserted on the next edge. The channels stay asserted for the whole time the flag is high.
- R8: A channel whose active ignore bit is set is never asserted, whatever source requests sync.
- R9: When several sources overlap, the channels are released only on the edge after the last remaining source has gone inactive (after that source's own latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_pin_n | input | 1 | Asynchronous active-low manual sync pin |
| chip_rst_n | input | 1 | Asynchronous active-low chip reset pin |
| pwr_dn_n | input | 1 | Asynchronous active-low power-down pin |
| cal_busy | input | 1 | Calibration in progress, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 control bits, 1 ignore mask |
| wr_data | input | DATA_W | Register write data |
| update_all | input | 1 | Commit all staging bits to the active copy |
| ch_sync_act | output | NUM_CH | Per-channel sync-active, registered |

## Verification
Every source is driven once with each of the 16 ignore masks. This separates a channel that is wrongly masked from a request that is wrongly merged. The outputs are sampled one edge before and one edge after the expected latency, so a missing or extra synchronizer stage shows up as a miscompare. The register path is checked at three points: after a write but before the update, right at the commit, and one edge after it. This shows whether staging actually holds the value back. Overlapping sources, such as pin with calibration and soft sync with chip reset, are released one at a time, and a reset pulse with a soft sync already committed shows whether reset clears the stored bits.

// File: rtl/sync_merge_pkg.sv
package sync_merge_pkg;

  localparam int CTRL_ADDR    = 0;
  localparam int IGNORE_ADDR  = 1;

  localparam int SOFT_SYNC_BIT = 0;
  localparam int PD_DIST_BIT   = 1;
  localparam int SOFT_RST_BIT  = 2;
  localparam int TRIG_BITS     = 3;

  typedef struct packed {
    logic soft_rst;
    logic pd_dist;
    logic soft_sync;
  } trig_t;

endpackage

// File: rtl/sync_cdc.sv
module sync_cdc #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sync_shadow_regs.sv
module sync_shadow_regs
  import sync_merge_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 1,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              update_all,
  output trig_t             trig_act,
  output logic [NUM_CH-1:0] ign_act
);

  trig_t             trig_stg;
  logic [NUM_CH-1:0] ign_stg;
  logic              hit_ctrl;
  logic              hit_ign;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign hit_ign  = wr_en && (wr_addr == ADDR_W'(IGNORE_ADDR));

  // staging copy, written by the port
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_stg <= '0;
      ign_stg  <= '0;
    end else begin
      if (hit_ctrl) begin
        trig_stg.soft_sync <= wr_data[SOFT_SYNC_BIT];
        trig_stg.pd_dist   <= wr_data[PD_DIST_BIT];
        trig_stg.soft_rst  <= wr_data[SOFT_RST_BIT];
      end
      if (hit_ign) ign_stg <= wr_data[NUM_CH-1:0];
    end
  end

  // active copy, loaded only by the update strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      trig_act <= '0;
      ign_act  <= '0;
    end else if (update_all) begin
      trig_act <= trig_stg;
      ign_act  <= ign_stg;
    end
  end

endmodule

// File: rtl/sync_pwrup_timer.sv
module sync_pwrup_timer #(
  parameter int HOLD = 8
) (
  input  logic clk,
  input  logic rst,
  output logic hold_on
);

  localparam int CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)              remain <= CNT_W'(HOLD);
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign hold_on = (remain != 0);

endmodule

// File: rtl/sync_merge_ctrl.sv
module sync_merge_ctrl
  import sync_merge_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 1,
  parameter int DATA_W     = (NUM_CH > TRIG_BITS) ? NUM_CH : TRIG_BITS,
  parameter int CDC_STAGES = 2,
  parameter int PWRUP_HOLD = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_pin_n,
  input  logic              chip_rst_n,
  input  logic              pwr_dn_n,
  input  logic              cal_busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              update_all,
  output logic [NUM_CH-1:0] ch_sync_act
);

  localparam int NUM_PINS = 3;

  logic [NUM_PINS-1:0] pins_raw;
  logic [NUM_PINS-1:0] pins_sync;
  trig_t               trig_act;
  logic [NUM_CH-1:0]   ign_act;
  logic                pwrup_on;
  logic                any_src;
  logic [NUM_CH-1:0]   ch_next;

  // pin order: 0 manual sync, 1 chip reset, 2 power-down
  assign pins_raw = {pwr_dn_n, chip_rst_n, sync_pin_n};

  sync_cdc #(
    .WIDTH  (NUM_PINS),
    .STAGES (CDC_STAGES),
    .RST_VAL(1'b1)
  ) pin_cdc_i (
    .clk    (clk),
    .rst    (rst),
    .d_async(pins_raw),
    .q_sync (pins_sync)
  );

  sync_shadow_regs #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .update_all(update_all),
    .trig_act  (trig_act),
    .ign_act   (ign_act)
  );

  sync_pwrup_timer #(
    .HOLD(PWRUP_HOLD)
  ) pwrup_i (
    .clk    (clk),
    .rst    (rst),
    .hold_on(pwrup_on)
  );

  // any single active source holds the whole group
  assign any_src = pwrup_on | cal_busy | (~&pins_sync) | (|trig_act);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign ch_next[ch] = any_src & ~ign_act[ch];
  end

  always_ff @(posedge clk) begin
    if (rst) ch_sync_act <= '0;
    else     ch_sync_act <= ch_next;
  end

endmodule

// File: rtl/sync_merge_chk.sv
module sync_merge_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_busy,
  input logic              update_all,
  input logic [2:0]        pins_sync,
  input logic [NUM_CH-1:0] ign_act,
  input logic [NUM_CH-1:0] ch_sync_act
);

  // R2
  pwrup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> ((ch_sync_act | $past(ign_act)) == {NUM_CH{1'b1}}));

  // R3
  sync_pin_chk: assert property (@(posedge clk) disable iff (rst)
    !pins_sync[0] |=> ((ch_sync_act | $past(ign_act)) == {NUM_CH{1'b1}}));

  // R4
  chip_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (!pins_sync[1] || !pins_sync[2]) |=> ((ch_sync_act | $past(ign_act)) == {NUM_CH{1'b1}}));

  // R5
  no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !update_all |=> $stable(ign_act));

  // R7
  cal_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cal_busy |=> ((ch_sync_act | $past(ign_act)) == {NUM_CH{1'b1}}));

  // R8
  ignore_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ign_act != '0) |=> ((ch_sync_act & $past(ign_act)) == '0));

endmodule

bind sync_merge_ctrl sync_merge_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .cal_busy   (cal_busy),
  .update_all (update_all),
  .pins_sync  (pins_sync),
  .ign_act    (ign_act),
  .ch_sync_act(ch_sync_act)
);

// File: tb/sync_merge_ctrl_tb.sv
module sync_merge_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 4;
  localparam int HOLD       = 8;
  localparam int DW         = 4;
  localparam int WDOG_LIMIT = 100000;
  localparam logic [NCH-1:0] ALL = {NCH{1'b1}};

  logic           clk = 1'b0;
  logic           rst;
  logic           sync_pin_n, chip_rst_n, pwr_dn_n, cal_busy;
  logic           wr_en, update_all;
  logic [0:0]     wr_addr;
  logic [DW-1:0]  wr_data;
  logic [NCH-1:0] ch_sync_act;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_merge_ctrl #(.NUM_CH(NCH), .PWRUP_HOLD(HOLD)) dut_i (
    .clk(clk), .rst(rst), .sync_pin_n(sync_pin_n), .chip_rst_n(chip_rst_n),
    .pwr_dn_n(pwr_dn_n), .cal_busy(cal_busy), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .update_all(update_all), .ch_sync_act(ch_sync_act)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WDOG_LIMIT) begin
      fails = fails + 1;
      $display("FAIL watchdog: got %0d cycles, expected under %0d", cycles, WDOG_LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [NCH-1:0] exp);
    vectors++;
    if (ch_sync_act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, ch_sync_act, exp);
    end
  endtask

  task automatic reg_write(input logic [0:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic commit();
    update_all = 1'b1;
    tick(1);
    update_all = 1'b0;
  endtask

  task automatic set_mask(input logic [NCH-1:0] m);
    reg_write(1'b1, DW'(m));
    commit();
    tick(1);
  endtask

  task automatic drive_pin(input int which, input logic v);
    case (which)
      0: sync_pin_n = v;
      1: chip_rst_n = v;
      default: pwr_dn_n = v;
    endcase
  endtask

  initial begin
    rst = 1'b1; sync_pin_n = 1'b1; chip_rst_n = 1'b1; pwr_dn_n = 1'b1;
    cal_busy = 1'b0; wr_en = 1'b0; update_all = 1'b0; wr_addr = '0; wr_data = '0;
    tick(3);
    check("R1 reset", '0);

    // R2: power-up hold
    rst = 1'b0;
    for (int k = 1; k <= HOLD; k++) begin
      tick(1);
      check("R2 pwrup hold", ALL);
    end
    tick(1);
    check("R2 pwrup release", '0);

    // R5/R6: soft bits through staging and update
    for (int b = 0; b < 3; b++) begin
      for (int m = 0; m < (1 << NCH); m++) begin
        set_mask(NCH'(m));
        check("R8 idle", '0);
        reg_write(1'b0, DW'(1 << b));
        tick(1);
        check("R5 staged set", '0);
        commit();
        check("R6 at commit", '0);
        tick(1);
        check("R6 committed set", ~NCH'(m));
        reg_write(1'b0, '0);
        tick(1);
        check("R5 staged clear", ~NCH'(m));
        commit();
        tick(1);
        check("R6 committed clear", '0);
      end
    end

    // R3/R4: pins with every mask
    for (int p = 0; p < 3; p++) begin
      for (int m = 0; m < (1 << NCH); m++) begin
        set_mask(NCH'(m));
        drive_pin(p, 1'b0);
        tick(2);
        check(p == 0 ? "R3 early" : "R4 early", '0);
        tick(1);
        check(p == 0 ? "R3 assert" : "R4 assert", ~NCH'(m));
        tick(3);
        check(p == 0 ? "R3 hold" : "R4 hold", ~NCH'(m));
        drive_pin(p, 1'b1);
        tick(2);
        check(p == 0 ? "R3 late" : "R4 late", ~NCH'(m));
        tick(1);
        check(p == 0 ? "R3 release" : "R4 release", '0);
      end
    end

    // R7: calibration busy with every mask
    for (int m = 0; m < (1 << NCH); m++) begin
      set_mask(NCH'(m));
      cal_busy = 1'b1;
      tick(1);
      check("R7 assert", ~NCH'(m));
      tick(4);
      check("R7 hold", ~NCH'(m));
      cal_busy = 1'b0;
      tick(1);
      check("R7 release", '0);
    end

    // R9: overlapping sources
    set_mask('0);
    sync_pin_n = 1'b0;
    tick(3);
    cal_busy = 1'b1;
    tick(2);
    cal_busy = 1'b0;
    tick(2);
    check("R9 pin outlasts cal", ALL);
    sync_pin_n = 1'b1;
    tick(2);
    check("R9 pin late", ALL);
    tick(1);
    check("R9 all released", '0);

    reg_write(1'b0, DW'(1));
    commit();
    chip_rst_n = 1'b0;
    tick(4);
    reg_write(1'b0, '0);
    commit();
    tick(2);
    check("R9 chip pin outlasts soft", ALL);
    chip_rst_n = 1'b1;
    tick(3);
    check("R9 soft and pin released", '0);

    // R1: reset clears committed and staged bits
    reg_write(1'b0, DW'(1 << 2));
    commit();
    reg_write(1'b1, DW'(4'b0101));
    rst = 1'b1;
    tick(3);
    check("R1 reset under soft sync", '0);
    rst = 1'b0;
    tick(HOLD + 1);
    check("R1 bits cleared", '0);
    commit();
    tick(1);
    check("R1 staging cleared", '0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule